// File: doc/BRIEF.md
# Block-transfer micro-op sequencer

The sequencer sits behind the decoder of a processor pipeline. It takes one decoded block-transfer instruction and expands it into single-register micro-operations, one per clock, on a valid/ready output. Each instruction carries a 16-bit register mask, a base register number and five mode flags: pre-index, ascending direction, user-bank redirect, base writeback and load.

Every expansion starts with a base-copy micro-op, which latches the base register into a scratch address register. One transfer micro-op follows for each set bit of the mask, visited from bit 0 upward, and each transfer carries its byte offset from that scratch address. When writeback is requested, a base-update micro-op closes the sequence and moves the base by four bytes per transferred register.

The block computes the offset pattern for both directions itself. It can also redirect every transfer to the user-mode register bank. A `last` flag marks the final micro-op of each instruction. A new instruction is taken only while the block is idle.

Top module: `lsm_useq`

## Requirements
- R1: After reset, `uop_valid_o` is low and `in_ready_o` is high.
- R2: `in_ready_o` is high only while no micro-op is pending. An instruction is taken on a clock where `in_valid_i` and `in_ready_o` are both high. While the block is busy, `in_valid_i` and the instruction fields have no effect. The cycle after acceptance presents a base-copy micro-op: kind 0, reg equal to the base register, offset 0.
- R3: One instruction yields exactly popcount(mask) + writeback + 1 micro-ops. `uop_last_o` is high on the final one only, and `in_ready_o` is high again the cycle after that micro-op is taken.
- R4: Transfer micro-ops follow the base copy in ascending bit order of the mask. Their kind is 1 (load) when the load flag is set and 2 (store) otherwise.
- R5: When the direction is ascending, the first transfer offset is 0, or 4 when pre-index is set. Each later transfer adds 4.
- R6: When the direction is descending, the first transfer offset is 4·n − 4, plus 4 when pre-index is set, where n is the mask popcount. Each later transfer subtracts 4.
- R7: When the user-bank flag is set, each transfer's reg equals the bit number plus USER_OFS (default 32). Base-copy and base-update micro-ops always carry the unmodified base register.
- R8: When writeback is set, the last micro-op is a base update with reg equal to the base register and offset 4·n. Its kind is 3 (add) when ascending and 4 (subtract) when descending.
- R9: An empty mask yields only the base copy, plus the base update when writeback is set. The base update then has offset 0.
- R10: While `uop_valid_o` is high and `uop_ready_i` is low, every micro-op output holds its value into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Instruction offered |
| in_ready_o | output | 1 | Sequencer idle, instruction can be taken |
| mask_i | input | 16 | Register mask, bit k selects register k |
| base_i | input | 4 | Base register number |
| pre_i | input | 1 | Pre-index: offset starts one word further |
| up_i | input | 1 | 1 = ascending, 0 = descending |
| user_i | input | 1 | Redirect transfers to the user register bank |
| wb_i | input | 1 | Append a base-update micro-op |
| load_i | input | 1 | 1 = load transfers, 0 = store transfers |
| uop_valid_o | output | 1 | Micro-op presented |
| uop_ready_i | input | 1 | Consumer takes the micro-op |
| uop_kind_o | output | 3 | 0 copy, 1 load, 2 store, 3 base add, 4 base subtract |
| uop_reg_o | output | 6 | Register index |
| uop_off_o | output | 7 | Byte offset or base-update amount |
| uop_last_o | output | 1 | Final micro-op of the instruction |

## Verification
The assertions check these properties on every cycle:
- mutual exclusion of `in_ready_o` and `uop_valid_o`;
- the base copy in the cycle after acceptance;
- output stability under backpressure;
- the ±4 offset step and strictly rising register index between consecutive transfers;
- the return to idle after a last micro-op.

The exact count of micro-ops, the first offset for each direction and pre-index combination, the user-bank shift and the writeback amount depend on the whole mask. Only the bench's sweep over masks and all 32 flag combinations can show them. That sweep also covers stalled consumers and junk instructions offered while busy.

// File: rtl/lsm_useq_pkg.sv
package lsm_useq_pkg;
  typedef enum logic [2:0] {
    UOP_COPY  = 3'd0,
    UOP_LOAD  = 3'd1,
    UOP_STORE = 3'd2,
    UOP_WB_UP = 3'd3,
    UOP_WB_DN = 3'd4
  } uop_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_COPY,
    ST_XFER,
    ST_WB
  } seq_state_e;
endpackage

// File: rtl/lsm_popcount.sv
module lsm_popcount #(
  parameter int W  = 16,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) cnt_o = cnt_o + CW'(vec_i[i]);
  end
endmodule

// File: rtl/lsm_lowbit.sv
module lsm_lowbit #(
  parameter int W  = 16,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  // scan downward so the lowest set bit wins
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
    any_o = |vec_i;
  end
endmodule

// File: rtl/lsm_useq.sv
module lsm_useq
  import lsm_useq_pkg::*;
#(
  parameter int LIST_W   = 16,
  parameter int USER_OFS = 32
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  in_valid_i,
  output logic                                  in_ready_o,
  input  logic [LIST_W-1:0]                     mask_i,
  input  logic [$clog2(LIST_W)-1:0]             base_i,
  input  logic                                  pre_i,
  input  logic                                  up_i,
  input  logic                                  user_i,
  input  logic                                  wb_i,
  input  logic                                  load_i,
  output logic                                  uop_valid_o,
  input  logic                                  uop_ready_i,
  output logic [2:0]                            uop_kind_o,
  output logic [$clog2(USER_OFS+LIST_W)-1:0]    uop_reg_o,
  output logic [$clog2(4*LIST_W+5)-1:0]         uop_off_o,
  output logic                                  uop_last_o
);
  localparam int BASE_W = $clog2(LIST_W);
  localparam int CNT_W  = $clog2(LIST_W + 1);
  localparam int IDX_W  = $clog2(USER_OFS + LIST_W);
  localparam int OFF_W  = $clog2(4 * LIST_W + 5);

  seq_state_e          state_q;
  logic [LIST_W-1:0]   mask_q;
  logic [BASE_W-1:0]   base_q;
  logic                up_q, user_q, wb_q, load_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [OFF_W-1:0]    off_q;

  logic [CNT_W-1:0]    in_cnt;
  logic [BASE_W-1:0]   low_idx;
  logic                low_any;
  logic [LIST_W-1:0]   mask_clr;
  logic [OFF_W-1:0]    start_off, pre_add;
  logic                accept, fire, is_xfer;

  lsm_popcount #(.W(LIST_W), .CW(CNT_W)) u_popcount (
    .vec_i (mask_i),
    .cnt_o (in_cnt)
  );

  lsm_lowbit #(.W(LIST_W), .IW(BASE_W)) u_lowbit (
    .vec_i (mask_q),
    .idx_o (low_idx),
    .any_o (low_any)
  );

  assign in_ready_o = (state_q == ST_IDLE);
  assign accept     = in_valid_i && in_ready_o;
  assign fire       = uop_valid_o && uop_ready_i;
  assign mask_clr   = mask_q & (mask_q - LIST_W'(1));
  assign pre_add    = pre_i ? OFF_W'(4) : '0;
  // descending start wraps for an empty mask but is never issued then
  assign start_off  = up_i ? pre_add
                           : ((OFF_W'(in_cnt) << 2) - OFF_W'(4) + pre_add);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mask_q  <= '0;
      base_q  <= '0;
      up_q    <= 1'b0;
      user_q  <= 1'b0;
      wb_q    <= 1'b0;
      load_q  <= 1'b0;
      cnt_q   <= '0;
      off_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          mask_q  <= mask_i;
          base_q  <= base_i;
          up_q    <= up_i;
          user_q  <= user_i;
          wb_q    <= wb_i;
          load_q  <= load_i;
          cnt_q   <= in_cnt;
          off_q   <= start_off;
          state_q <= ST_COPY;
        end
        ST_COPY: if (fire) begin
          if (low_any)   state_q <= ST_XFER;
          else if (wb_q) state_q <= ST_WB;
          else           state_q <= ST_IDLE;
        end
        ST_XFER: if (fire) begin
          mask_q <= mask_clr;
          off_q  <= up_q ? off_q + OFF_W'(4) : off_q - OFF_W'(4);
          if (mask_clr == '0) state_q <= wb_q ? ST_WB : ST_IDLE;
        end
        ST_WB: if (fire) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    uop_valid_o = (state_q != ST_IDLE);
    uop_kind_o  = UOP_COPY;
    uop_reg_o   = IDX_W'(base_q);
    uop_off_o   = '0;
    uop_last_o  = 1'b0;
    unique case (state_q)
      ST_COPY: uop_last_o = !low_any && !wb_q;
      ST_XFER: begin
        uop_kind_o = load_q ? UOP_LOAD : UOP_STORE;
        uop_reg_o  = IDX_W'(low_idx) + (user_q ? IDX_W'(USER_OFS) : '0);
        uop_off_o  = off_q;
        uop_last_o = (mask_clr == '0) && !wb_q;
      end
      ST_WB: begin
        uop_kind_o = up_q ? UOP_WB_UP : UOP_WB_DN;
        uop_off_o  = OFF_W'(cnt_q) << 2;
        uop_last_o = 1'b1;
      end
      default: ;
    endcase
  end

  assign is_xfer = (uop_kind_o == UOP_LOAD) || (uop_kind_o == UOP_STORE);

  AST_IDLE_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> !uop_valid_o); // R2
  AST_ACCEPT_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> uop_valid_o && uop_kind_o == UOP_COPY && uop_off_o == '0); // R2
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_valid_o && !uop_ready_i |=> uop_valid_o && $stable(uop_kind_o)
      && $stable(uop_reg_o) && $stable(uop_off_o) && $stable(uop_last_o)); // R10
  AST_LAST_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && uop_last_o |=> in_ready_o); // R3
  AST_OFF_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && is_xfer |=> !is_xfer ||
      uop_off_o == (up_q ? $past(uop_off_o) + OFF_W'(4)
                         : $past(uop_off_o) - OFF_W'(4))); // R5
  AST_REG_ASCEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && is_xfer |=> !is_xfer || uop_reg_o > $past(uop_reg_o)); // R4
  AST_WB_IS_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uop_kind_o == UOP_WB_UP || uop_kind_o == UOP_WB_DN) |-> uop_last_o); // R8
  AST_LOWBIT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_XFER |-> mask_q[low_idx]); // R4
endmodule

// File: tb/lsm_useq_bench.sv
module lsm_useq_bench;
  localparam int LIST_W   = 16;
  localparam int USER_OFS = 32;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [15:0] mask_i = '0;
  logic [3:0]  base_i = '0;
  logic        pre_i = 0, up_i = 0, user_i = 0, wb_i = 0, load_i = 0;
  logic        uop_valid_o;
  logic        uop_ready_i = 1'b0;
  logic [2:0]  uop_kind_o;
  logic [5:0]  uop_reg_o;
  logic [6:0]  uop_off_o;
  logic        uop_last_o;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  always #2 clk_i = ~clk_i;

  lsm_useq #(.LIST_W(LIST_W), .USER_OFS(USER_OFS)) u_lsm_useq (
    .clk_i, .rst_ni, .in_valid_i, .in_ready_o, .mask_i, .base_i,
    .pre_i, .up_i, .user_i, .wb_i, .load_i, .uop_valid_o, .uop_ready_i,
    .uop_kind_o, .uop_reg_o, .uop_off_o, .uop_last_o
  );

  task automatic chk(input bit ok, input string req, input string msg);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s", req, msg);
    end
  endtask

  function automatic int nth_bit(input logic [15:0] m, input int j);
    int seen = 0;
    for (int b = 0; b < 16; b++) begin
      if (m[b]) begin
        if (seen == j) return b;
        seen++;
      end
    end
    return -1;
  endfunction

  task automatic run(input logic [15:0] m, input logic [3:0] b,
                     input logic [4:0] f, input bit stall, input bit junk);
    int n = $countones(m);
    int total = n + int'(f[3]) + 1;
    int idx = 0;
    int cyc = 0;
    bit held = 0;
    logic [2:0] pk;
    logic [5:0] pr;
    logic [6:0] po;
    logic pl;
    int ek, er, eo;
    bit el;
    string rq;
    @(negedge clk_i);
    in_valid_i = 1'b1;
    mask_i = m; base_i = b;
    pre_i = f[0]; up_i = f[1]; user_i = f[2]; wb_i = f[3]; load_i = f[4];
    @(negedge clk_i);
    if (junk) begin
      mask_i = ~m; base_i = ~b;
      {load_i, wb_i, user_i, up_i, pre_i} = ~f;
    end else in_valid_i = 1'b0;
    while (idx < total) begin
      uop_ready_i = stall ? ((cyc % 3) != 1) : 1'b1;
      if (idx == 0) begin
        ek = 0; er = b; eo = 0; rq = "R2";
      end else if (idx <= n) begin
        ek = f[4] ? 1 : 2;
        er = nth_bit(m, idx - 1) + (f[2] ? USER_OFS : 0);
        eo = f[1] ? (f[0] ? 4 : 0) + 4 * (idx - 1)
                  : 4 * n - 4 + (f[0] ? 4 : 0) - 4 * (idx - 1);
        rq = f[2] ? (f[1] ? "R4 R5 R7" : "R4 R6 R7") : (f[1] ? "R4 R5" : "R4 R6");
      end else begin
        ek = f[1] ? 3 : 4; er = b; eo = 4 * n;
        rq = (n == 0) ? "R8 R9" : "R8";
      end
      el = (idx == total - 1);
      chk(uop_valid_o && !in_ready_o && uop_kind_o == 3'(ek) &&
          uop_reg_o == 6'(er) && uop_off_o == 7'(eo), rq,
          $sformatf("uop %0d mask %h flags %b: act v%0b r%0b k%0d g%0d o%0d exp k%0d g%0d o%0d",
                    idx, m, f, uop_valid_o, in_ready_o, uop_kind_o, uop_reg_o,
                    uop_off_o, ek, er, eo));
      chk(uop_last_o == el, "R3",
          $sformatf("last at uop %0d mask %h flags %b: act %0b exp %0b",
                    idx, m, f, uop_last_o, el));
      if (held)
        chk(uop_kind_o == pk && uop_reg_o == pr && uop_off_o == po && uop_last_o == pl,
            "R10", $sformatf("stall hold: act k%0d g%0d o%0d exp k%0d g%0d o%0d",
                             uop_kind_o, uop_reg_o, uop_off_o, pk, pr, po));
      if (uop_ready_i) begin
        idx++;
        held = 0;
        if (idx == total) in_valid_i = 1'b0;
      end else begin
        held = 1;
        pk = uop_kind_o; pr = uop_reg_o; po = uop_off_o; pl = uop_last_o;
      end
      cyc++;
      if (cyc > 200) begin
        chk(1'b0, "R3", $sformatf("sequence stuck: act %0d taken exp %0d", idx, total));
        break;
      end
      @(negedge clk_i);
    end
    uop_ready_i = 1'b0;
    in_valid_i = 1'b0;
    chk(!uop_valid_o && in_ready_o, "R3",
        $sformatf("after last: act v%0b r%0b exp v0 r1", uop_valid_o, in_ready_o));
  endtask

  logic [15:0] masks [10];

  initial begin
    masks = '{16'h0000, 16'h0001, 16'h8000, 16'hFFFF, 16'h00F0,
              16'hA5A5, 16'h5A5A, 16'h0180, 16'h7FFE, 16'h1248};
    #5;
    chk(!uop_valid_o && in_ready_o, "R1",
        $sformatf("in reset: act v%0b r%0b exp v0 r1", uop_valid_o, in_ready_o));
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!uop_valid_o && in_ready_o, "R1",
        $sformatf("after reset: act v%0b r%0b exp v0 r1", uop_valid_o, in_ready_o));
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < 10; i++) begin
        for (int f = 0; f < 32; f++) begin
          run(masks[i], 4'((i * 5 + f) % 16), 5'(f), s[0], s[0] && (f % 4 == 0));
        end
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: act %0d cycles exp completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule